// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This unit takes one arithmetic request at a time: two operands, an opcode and a saturation width. It returns one registered result. Every operation clamps instead of wrapping. The one exception is a wrapping add that only reports overflow. The operations are:

- signed add, signed subtract and signed doubling;
- unsigned add and unsigned subtract;
- saturation to a programmable bit width, signed or unsigned, on the whole word or on two 16-bit halves independently.

Every clamp raises a sticky flag that all operations share. The flag stays set until the dedicated clear input drops it. This lets software run a whole sequence of operations and then ask once whether any of them saturated.

Requests enter on a valid/ready handshake. The unit holds one result in an output register. A request is accepted when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` is high when the output register is empty, or when it is being drained in the same cycle (`out_ready` high). A result with `out_valid` high stays unchanged until `out_ready` is high on an edge.

Top module: `sat_unit`

## Requirements
- R1: Opcode 0 (signed add) and opcode 1 (signed subtract) return `opa+opb` or `opa-opb`. On signed overflow the result clamps to 0x7FFFFFFF when `opa` is non-negative and to 0x80000000 when `opa` is negative.
- R2: Opcode 2 (signed doubling of `opa`) returns 0x7FFFFFFF for inputs at or above 0x40000000 (as signed). It returns 0x80000000 for inputs at or below 0xC0000000 (as signed). Any other input is shifted left by one.
- R3: Opcode 3 (unsigned add) returns all ones when the sum carries out. Opcode 4 (unsigned subtract) returns zero when `opb` exceeds `opa`.
- R4: Opcode 5 saturates signed `opa` to width n = `sat_width`. The value `opa` arithmetically shifted right by n is checked. If it is above 0, the result is (1<<n)-1. If it is below -1, the result is the complement of that mask. Otherwise `opa` passes through unchanged.
- R5: Opcode 6 saturates `opa` unsigned to width n. A negative input gives 0. An input above (1<<n)-1 gives that mask. Any other input passes through.
- R6: Opcode 7 (signed) and opcode 8 (unsigned) apply R4 and R5 to each sign-extended 16-bit half of `opa` on its own. The low 16 bits of each lane result go back to the same half.
- R7: Opcode 9 returns the wrapped sum `opa+opb` and sets the sticky flag on signed overflow.
- R8: Every clamp sets `sat_flag` on the edge that accepts the request. An operation that does not clamp never clears it.
- R9: `sat_clear` drops the flag on the next edge. If an operation that clamps is accepted on the same edge, the flag ends set.
- R10: The result and `out_valid` appear on the edge that accepts the request. While `out_ready` is low, `in_ready` is low and the result stays unchanged.
- R11: After reset, `out_valid`, `sat_flag` and `result` are all zero.
- R12: Opcodes 10 to 15 return zero and do not touch the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| in_valid | input | 1 | request present |
| in_ready | output | 1 | unit can accept a request |
| op | input | 4 | operation code |
| opa | input | 32 | first operand |
| opb | input | 32 | second operand |
| sat_width | input | 5 | bit width n for width saturation |
| out_valid | output | 1 | result register holds a result |
| out_ready | input | 1 | consumer takes the result |
| result | output | 32 | registered result |
| sat_clear | input | 1 | clears the sticky flag |
| sat_flag | output | 1 | sticky saturation flag |

## Verification
Each result and its flag update belong to the edge that accepts the request. The bench therefore drives a request at a falling edge and samples `result` and `sat_flag` at the following falling edge, exactly one edge later. A clear is sampled one edge after it is driven. Under back-pressure, the bench samples over several stalled edges to confirm that nothing moves. It then checks that the result of the waiting request appears one edge after `out_ready` returns high.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [3:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_SDBL   = 4'd2,
    OP_UADD   = 4'd3,
    OP_USUB   = 4'd4,
    OP_SSATW  = 4'd5,
    OP_USATW  = 4'd6,
    OP_SSAT16 = 4'd7,
    OP_USAT16 = 4'd8,
    OP_WADD   = 4'd9
  } sat_op_e;
endpackage

// File: rtl/sat_arith.sv
// Add/subtract/doubling datapath with clamp detection.
module sat_arith
  import sat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              hit
);
  localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] DBL_HI = {2'b01, {(DATA_W-2){1'b0}}};
  localparam logic [DATA_W-1:0] DBL_LO = {2'b11, {(DATA_W-2){1'b0}}};

  logic [DATA_W:0]   usum;
  logic [DATA_W-1:0] sum, diff, clampv;
  logic              add_ovf, sub_ovf, dbl_hi, dbl_lo;

  assign usum    = {1'b0, a} + {1'b0, b};
  assign sum     = usum[DATA_W-1:0];
  assign diff    = a - b;
  assign add_ovf = (a[DATA_W-1] == b[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
  assign sub_ovf = (a[DATA_W-1] != b[DATA_W-1]) && (diff[DATA_W-1] != a[DATA_W-1]);
  assign clampv  = a[DATA_W-1] ? SMIN : SMAX;
  assign dbl_hi  = $signed(a) >= $signed(DBL_HI);
  assign dbl_lo  = $signed(a) <= $signed(DBL_LO);

  always_comb begin
    res = '0;
    hit = 1'b0;
    case (op)
      OP_SADD: begin res = add_ovf ? clampv : sum;  hit = add_ovf; end
      OP_SSUB: begin res = sub_ovf ? clampv : diff; hit = sub_ovf; end
      OP_SDBL: begin
        if (dbl_hi)      begin res = SMAX; hit = 1'b1; end
        else if (dbl_lo) begin res = SMIN; hit = 1'b1; end
        else             res = {a[DATA_W-2:0], 1'b0};
      end
      OP_UADD: begin res = usum[DATA_W] ? '1 : sum; hit = usum[DATA_W]; end
      OP_USUB: begin res = (b > a) ? '0 : diff; hit = (b > a); end
      OP_WADD: begin res = sum; hit = add_ovf; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sat_clamp.sv
// Clamp a signed value to n bits, signed or unsigned.
module sat_clamp #(
  parameter int DATA_W = 32,
  parameter int SW_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val,
  input  logic [SW_W-1:0]   width,
  input  logic              signed_mode,
  output logic [DATA_W-1:0] res,
  output logic              hit
);
  logic [DATA_W-1:0] top, mask;
  logic              top_pos, top_below;

  assign top       = DATA_W'($signed(val) >>> width);
  assign mask      = (DATA_W'(1) << width) - DATA_W'(1);
  assign top_pos   = !top[DATA_W-1] && (top != '0);
  assign top_below = top[DATA_W-1] && !(&top);

  always_comb begin
    res = val;
    hit = 1'b0;
    if (signed_mode) begin
      if (top_pos)        begin res = mask;  hit = 1'b1; end
      else if (top_below) begin res = ~mask; hit = 1'b1; end
    end else begin
      if (val[DATA_W-1])  begin res = '0;    hit = 1'b1; end
      else if (val > mask) begin res = mask; hit = 1'b1; end
    end
  end
endmodule

// File: rtl/sat_unit.sv
module sat_unit
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SW_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [SW_W-1:0]   sat_width,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  input  logic              sat_clear,
  output logic              sat_flag
);
  localparam int LANE_W = DATA_W / 2;
  localparam int LANES  = 2;

  logic [DATA_W-1:0] ar_res, wd_res, ln_res, nxt_res;
  logic              ar_hit, wd_hit, nxt_hit, fire, lane_signed;
  logic [LANES-1:0]  ln_hit;

  sat_arith #(.DATA_W(DATA_W)) u_arith (
    .op(op), .a(opa), .b(opb), .res(ar_res), .hit(ar_hit)
  );

  sat_clamp #(.DATA_W(DATA_W), .SW_W(SW_W)) u_word (
    .val(opa), .width(sat_width), .signed_mode(op == OP_SSATW),
    .res(wd_res), .hit(wd_hit)
  );

  assign lane_signed = (op == OP_SSAT16);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] ext, lres;
    assign ext = {{(DATA_W-LANE_W){opa[g*LANE_W+LANE_W-1]}}, opa[g*LANE_W +: LANE_W]};
    sat_clamp #(.DATA_W(DATA_W), .SW_W(SW_W)) u_lane (
      .val(ext), .width(sat_width), .signed_mode(lane_signed),
      .res(lres), .hit(ln_hit[g])
    );
    assign ln_res[g*LANE_W +: LANE_W] = lres[LANE_W-1:0];
  end

  always_comb begin
    case (op)
      OP_SSATW, OP_USATW:   begin nxt_res = wd_res; nxt_hit = wd_hit; end
      OP_SSAT16, OP_USAT16: begin nxt_res = ln_res; nxt_hit = |ln_hit; end
      default:              begin nxt_res = ar_res; nxt_hit = ar_hit; end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        result    <= nxt_res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      sat_flag <= (sat_flag && !sat_clear) || (fire && nxt_hit);
    end
  end
endmodule

// File: rtl/sat_unit_checker.sv
module sat_unit_checker #(
  parameter int DATA_W = 32,
  parameter int SW_W   = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        op,
  input logic [DATA_W-1:0] opa,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] result,
  input logic              sat_clear,
  input logic              sat_flag
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clear |=> sat_flag);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clear && !(in_valid && in_ready) |=> !sat_flag);

  assert_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> $past(in_valid && in_ready));

  assert_uadd_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op == 4'd3 |=> result >= $past(opa));
endmodule

bind sat_unit sat_unit_checker #(.DATA_W(DATA_W), .SW_W(SW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op(op), .opa(opa), .out_valid(out_valid), .out_ready(out_ready),
  .result(result), .sat_clear(sat_clear), .sat_flag(sat_flag)
);

// File: tb/sat_unit_test.sv
module sat_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1, sat_clear = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [4:0]  sat_width = '0;
  logic        in_ready, out_valid, sat_flag;
  logic [31:0] result;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  sat_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .opa(opa), .opb(opb), .sat_width(sat_width),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .sat_clear(sat_clear), .sat_flag(sat_flag)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  w;
    logic [31:0] exp;
    logic        hit;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    '{4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h7FFFFFFF, 1'b1},
    '{4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h80000000, 1'b1},
    '{4'd0, 32'h00000005, 32'h00000003, 5'd0, 32'h00000008, 1'b0},
    '{4'd1, 32'h80000000, 32'h00000001, 5'd0, 32'h80000000, 1'b1},
    '{4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 32'h7FFFFFFF, 1'b1},
    '{4'd1, 32'h0000000A, 32'h00000003, 5'd0, 32'h00000007, 1'b0},
    '{4'd2, 32'h40000000, 32'h0, 5'd0, 32'h7FFFFFFF, 1'b1},
    '{4'd2, 32'hC0000000, 32'h0, 5'd0, 32'h80000000, 1'b1},
    '{4'd2, 32'hC0000001, 32'h0, 5'd0, 32'h80000002, 1'b0},
    '{4'd2, 32'h3FFFFFFF, 32'h0, 5'd0, 32'h7FFFFFFE, 1'b0},
    '{4'd3, 32'hFFFFFFFF, 32'h00000002, 5'd0, 32'hFFFFFFFF, 1'b1},
    '{4'd3, 32'h00000001, 32'h00000002, 5'd0, 32'h00000003, 1'b0},
    '{4'd4, 32'h00000001, 32'h00000002, 5'd0, 32'h00000000, 1'b1},
    '{4'd4, 32'h00000005, 32'h00000005, 5'd0, 32'h00000000, 1'b0},
    '{4'd5, 32'h00001000, 32'h0, 5'd8, 32'h000000FF, 1'b1},
    '{4'd5, 32'hFFFFF000, 32'h0, 5'd8, 32'hFFFFFF00, 1'b1},
    '{4'd5, 32'h0000007F, 32'h0, 5'd8, 32'h0000007F, 1'b0},
    '{4'd5, 32'hFFFFFF80, 32'h0, 5'd7, 32'hFFFFFF80, 1'b0},
    '{4'd5, 32'h00000001, 32'h0, 5'd0, 32'h00000000, 1'b1},
    '{4'd6, 32'hFFFFFFFF, 32'h0, 5'd8, 32'h00000000, 1'b1},
    '{4'd6, 32'h00000100, 32'h0, 5'd8, 32'h000000FF, 1'b1},
    '{4'd6, 32'h000000FF, 32'h0, 5'd8, 32'h000000FF, 1'b0},
    '{4'd7, 32'h7FFF8000, 32'h0, 5'd8, 32'h00FFFF00, 1'b1},
    '{4'd7, 32'h0010FFF0, 32'h0, 5'd8, 32'h0010FFF0, 1'b0},
    '{4'd8, 32'h80000123, 32'h0, 5'd8, 32'h000000FF, 1'b1},
    '{4'd8, 32'h00120034, 32'h0, 5'd8, 32'h00120034, 1'b0},
    '{4'd9, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h80000000, 1'b1},
    '{4'd9, 32'hFFFFFFFF, 32'h00000001, 5'd0, 32'h00000000, 1'b0},
    '{4'd15, 32'h00000005, 32'h00000005, 5'd0, 32'h00000000, 1'b0}
  };

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R1";
      4'd2:       return "R2";
      4'd3, 4'd4: return "R3";
      4'd5:       return "R4";
      4'd6:       return "R5";
      4'd7, 4'd8: return "R6";
      4'd9:       return "R7";
      default:    return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk) sat_clear = 1'b1;
    @(negedge clk) sat_clear = 1'b0;
  endtask

  task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] w);
    @(negedge clk);
    op = o; opa = a; opb = b; sat_width = w; in_valid = 1'b1;
    @(negedge clk) in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 out_valid", {31'd0, out_valid}, 32'd0);
    check("R11 sat_flag", {31'd0, sat_flag}, 32'd0);
    check("R11 result", result, 32'd0);
    rst_n = 1'b1;

    // Vector table: each vector starts with a cleared flag
    for (int i = 0; i < NV; i++) begin
      do_clear();
      issue(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].w);
      check(req_of(TBL[i].op), result, TBL[i].exp);
      check({req_of(TBL[i].op), " flag R8"}, {31'd0, sat_flag}, {31'd0, TBL[i].hit});
    end

    // R8: clamp, then a non-clamping op keeps the flag
    do_clear();
    issue(4'd0, 32'h7FFFFFFF, 32'd1, 5'd0);
    issue(4'd0, 32'd1, 32'd1, 5'd0);
    check("R8 sticky", {31'd0, sat_flag}, 32'd1);
    check("R8 result", result, 32'd2);

    // R9: clear alone drops the flag
    do_clear();
    check("R9 clear", {31'd0, sat_flag}, 32'd0);

    // R9: clear with clamping op on the same edge leaves it set
    issue(4'd3, 32'hFFFFFFFF, 32'd1, 5'd0);
    @(negedge clk);
    op = 4'd4; opa = 32'd0; opb = 32'd1; in_valid = 1'b1; sat_clear = 1'b1;
    @(negedge clk) in_valid = 1'b0; sat_clear = 1'b0;
    check("R9 clear+clamp", {31'd0, sat_flag}, 32'd1);

    // R9: clear with non-clamping op ends cleared
    @(negedge clk);
    op = 4'd4; opa = 32'd3; opb = 32'd1; in_valid = 1'b1; sat_clear = 1'b1;
    @(negedge clk) in_valid = 1'b0; sat_clear = 1'b0;
    check("R9 clear+plain", {31'd0, sat_flag}, 32'd0);
    check("R9 result", result, 32'd2);

    // R12: reserved opcode leaves a set flag alone
    issue(4'd2, 32'h40000000, 32'd0, 5'd0);
    issue(4'd12, 32'd7, 32'd7, 5'd0);
    check("R12 result", result, 32'd0);
    check("R12 flag", {31'd0, sat_flag}, 32'd1);

    // R10: back-pressure
    @(negedge clk);
    check("R10 idle", {31'd0, out_valid}, 32'd0);
    out_ready = 1'b0;
    op = 4'd0; opa = 32'd5; opb = 32'd3; in_valid = 1'b1;
    @(negedge clk);
    check("R10 valid", {31'd0, out_valid}, 32'd1);
    check("R10 first", result, 32'd8);
    check("R10 not ready", {31'd0, in_ready}, 32'd0);
    opa = 32'd1; opb = 32'd1;
    repeat (3) @(negedge clk);
    check("R10 held", result, 32'd8);
    check("R10 still valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk) in_valid = 1'b0;
    check("R10 next", result, 32'd2);
    check("R10 next valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R10 drained", {31'd0, out_valid}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule